// File: doc/BRIEF.md
# Reduced-Speed Divider Controller with Automatic Wake

This block owns the divide ratio applied to the instruction clock. Software writes a mode code to ask for one of two reduced-speed settings. The request is armed at once, but the divider moves only on the next instruction-cycle boundary, which is given by `cyc_tick`. While a reduced setting is active, any interrupt request that the processor could actually take returns the divider to full speed on the following clock. A serial start bit on any port does the same. Software then sees its mode code cleared. An interrupt request that the level currently in service would lock out is ignored.

The block also keeps a software-written oscillator-source select. A wake never alters this value; only a write does. A status word reports the two in-service priority flags and the receive and transmit activity of each serial port. Software can read it before it enters a reduced mode.

The controller is a five-state machine:
- `ST_FULL`: full speed, nothing pending.
- `ST_ARM64` and `ST_ARM1K`: a request is accepted and waits for the cycle boundary.
- `ST_DIV64` and `ST_DIV1K`: the reduced ratio is active.

Transitions:
- arm: from `ST_FULL` on a write of a reduced code.
- commit: from an arm state to its divide state on `cyc_tick`.
- cancel: from an arm state to `ST_FULL` on a wake or a full-speed write.
- wake exit: from a divide state to `ST_FULL` on a qualified event.
- software exit: from a divide state to `ST_FULL` on a full-speed write.

Top module: `pmm_switchback_ctrl`

## Requirements
- R1: After reset, `div_sel` and `mode_q` are 2'b00 and `osc_sel` equals its reset parameter (1).
- R2: A write of a reduced code at full speed shows in `mode_q` on the next clock. `div_sel` takes that code only after the first clock at which `cyc_tick` is high.
- R3: Codes are 2'b00 full speed, 2'b01 divide-by-64 and 2'b10 divide-by-1024. A write of 2'b11 is ignored, and `div_sel` never reads 2'b11.
- R4: While a reduced ratio is active or armed, a write of the other reduced code (or 2'b11) is ignored. A write of 2'b00 returns `div_sel` and `mode_q` to 2'b00 on the next clock.
- R5: While a reduced ratio is active, a qualified wake forces `div_sel` and `mode_q` to 2'b00 on the next clock. The wake has priority over a simultaneous write.
- R6: An interrupt request qualifies only when it is not masked. With `svc_hi` set, no interrupt request qualifies. With only `svc_lo` set, only requests whose `irq_hi` bit is 1 qualify. With neither flag set, any request qualifies.
- R7: A serial start bit on any port qualifies as a wake whatever the in-service flags are.
- R8: A qualified wake while a request is armed cancels it. The divider stays at full speed even when `cyc_tick` later arrives.
- R9: `osc_sel` changes only on the clock after `osc_wr`, taking `osc_wdata`. A wake leaves it unchanged.
- R10: `status` bit 0 is `svc_hi` and bit 1 is `svc_lo`. For port p, bit 2+2p is `ser_rx_act[p]` and bit 3+2p is `ser_tx_act[p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | Instruction-cycle boundary strobe |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Requested divider code |
| osc_wr | input | 1 | Oscillator-select write strobe |
| osc_wdata | input | 1 | Oscillator-select value written |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_hi | input | N_IRQ | Per-source high-priority flag |
| svc_hi | input | 1 | High-priority level in service |
| svc_lo | input | 1 | Low-priority level in service |
| ser_start | input | N_SER | Serial start-bit detect per port |
| ser_rx_act | input | N_SER | Receive in progress per port |
| ser_tx_act | input | N_SER | Transmit in progress per port |
| div_sel | output | 2 | Active divider code |
| mode_q | output | 2 | Software-visible mode code |
| osc_sel | output | 1 | Held oscillator-source select |
| status | output | 2+2*N_SER | In-service and serial activity word |

## Verification
The bench goes after the masking corners. A low-priority request arrives while a low level is in service. Any request arrives while the high level is in service. A design that ignores the mask would drop to full speed too early. Other cases check that a direct jump between the two reduced codes and a 2'b11 write are refused; a design that accepted them would show a changed divider. A wake while a request is armed must leave the divider at full speed after the boundary; a design that ignored it would still enter the reduced ratio. Throughout, `osc_sel` is compared against a model that changes it only on writes, which catches a wake path that disturbs the source select.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
    typedef enum logic [2:0] {
        ST_FULL  = 3'd0,
        ST_ARM64 = 3'd1,
        ST_ARM1K = 3'd2,
        ST_DIV64 = 3'd3,
        ST_DIV1K = 3'd4
    } pmm_state_e;

    localparam logic [1:0] DIV_FULL = 2'b00;
    localparam logic [1:0] DIV_64   = 2'b01;
    localparam logic [1:0] DIV_1K   = 2'b10;
endpackage

// File: rtl/pmm_wake_qual.sv
module pmm_wake_qual #(
    parameter int N_IRQ = 6,
    parameter int N_SER = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_hi,
    input  logic             svc_hi,
    input  logic             svc_lo,
    input  logic [N_SER-1:0] ser_start,
    output logic             wake
);
    logic [N_IRQ-1:0] takeable;

    generate
        for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
            assign takeable[i] = irq_req[i] & ~svc_hi & (irq_hi[i] | ~svc_lo);
        end
    endgenerate

    assign wake = (|takeable) | (|ser_start);

    // R6
    hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_hi && ser_start == '0) |-> !wake)
        else $error("high level in service must mask all interrupt wakes");

    // R6
    lo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_lo && ser_start == '0 && (irq_req & irq_hi) == '0) |-> !wake)
        else $error("low level in service must mask low-priority wakes");

    // R7
    serial_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_start != '0) |-> wake)
        else $error("serial start bit must always wake");
endmodule

// File: rtl/pmm_status_pack.sv
module pmm_status_pack #(
    parameter int N_SER = 2,
    localparam int STAT_W = 2 + 2 * N_SER
) (
    input  logic              svc_hi,
    input  logic              svc_lo,
    input  logic [N_SER-1:0]  ser_rx_act,
    input  logic [N_SER-1:0]  ser_tx_act,
    output logic [STAT_W-1:0] status
);
    assign status[0] = svc_hi;
    assign status[1] = svc_lo;

    generate
        for (genvar p = 0; p < N_SER; p++) begin : g_port
            assign status[2 + 2*p] = ser_rx_act[p];
            assign status[3 + 2*p] = ser_tx_act[p];
        end
    endgenerate
endmodule

// File: rtl/pmm_mode_fsm.sv
module pmm_mode_fsm
    import pmm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_tick,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    input  logic       wake,
    output logic [1:0] div_sel,
    output logic [1:0] mode_q
);
    pmm_state_e state, state_nx;
    logic wr_full;

    assign wr_full = mode_wr && (mode_wdata == DIV_FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FULL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FULL: begin
                if (mode_wr && mode_wdata == DIV_64)      state_nx = ST_ARM64;
                else if (mode_wr && mode_wdata == DIV_1K) state_nx = ST_ARM1K;
            end
            ST_ARM64: begin
                if (wake || wr_full) state_nx = ST_FULL;
                else if (cyc_tick)   state_nx = ST_DIV64;
            end
            ST_ARM1K: begin
                if (wake || wr_full) state_nx = ST_FULL;
                else if (cyc_tick)   state_nx = ST_DIV1K;
            end
            ST_DIV64, ST_DIV1K: begin
                if (wake || wr_full) state_nx = ST_FULL;
            end
            default: state_nx = ST_FULL;
        endcase
    end

    always_comb begin
        div_sel = DIV_FULL;
        mode_q  = DIV_FULL;
        unique case (state)
            ST_FULL:  begin div_sel = DIV_FULL; mode_q = DIV_FULL; end
            ST_ARM64: begin div_sel = DIV_FULL; mode_q = DIV_64;   end
            ST_ARM1K: begin div_sel = DIV_FULL; mode_q = DIV_1K;   end
            ST_DIV64: begin div_sel = DIV_64;   mode_q = DIV_64;   end
            ST_DIV1K: begin div_sel = DIV_1K;   mode_q = DIV_1K;   end
            default:  begin div_sel = DIV_FULL; mode_q = DIV_FULL; end
        endcase
    end

    // R5
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel != DIV_FULL && wake) |=> (div_sel == DIV_FULL && mode_q == DIV_FULL))
        else $error("wake must restore full speed next clock");

    // R4
    no_direct_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel != DIV_FULL && mode_wr && mode_wdata != DIV_FULL && !wake) |=> $stable(div_sel))
        else $error("direct move between reduced ratios must be refused");

    // R2
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == DIV_FULL && !cyc_tick) |=> div_sel == DIV_FULL)
        else $error("divider may only slow down on a cycle boundary");

    // R3
    legal_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_sel != 2'b11)
        else $error("illegal divider code");
endmodule

// File: rtl/pmm_switchback_ctrl.sv
module pmm_switchback_ctrl #(
    parameter int   N_IRQ   = 6,
    parameter int   N_SER   = 2,
    parameter logic OSC_RST = 1'b1,
    localparam int  STAT_W  = 2 + 2 * N_SER
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              mode_wr,
    input  logic [1:0]        mode_wdata,
    input  logic              osc_wr,
    input  logic              osc_wdata,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_hi,
    input  logic              svc_hi,
    input  logic              svc_lo,
    input  logic [N_SER-1:0]  ser_start,
    input  logic [N_SER-1:0]  ser_rx_act,
    input  logic [N_SER-1:0]  ser_tx_act,
    output logic [1:0]        div_sel,
    output logic [1:0]        mode_q,
    output logic              osc_sel,
    output logic [STAT_W-1:0] status
);
    logic wake;

    pmm_wake_qual #(.N_IRQ(N_IRQ), .N_SER(N_SER)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .irq_hi    (irq_hi),
        .svc_hi    (svc_hi),
        .svc_lo    (svc_lo),
        .ser_start (ser_start),
        .wake      (wake)
    );

    pmm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_tick   (cyc_tick),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .wake       (wake),
        .div_sel    (div_sel),
        .mode_q     (mode_q)
    );

    pmm_status_pack #(.N_SER(N_SER)) u_stat (
        .svc_hi     (svc_hi),
        .svc_lo     (svc_lo),
        .ser_rx_act (ser_rx_act),
        .ser_tx_act (ser_tx_act),
        .status     (status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      osc_sel <= OSC_RST;
        else if (osc_wr) osc_sel <= osc_wdata;
    end

    // R9
    osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_wr |=> $stable(osc_sel))
        else $error("source select changed without a write");
endmodule

// File: tb/tb_pmm_switchback_ctrl.sv
`timescale 1ns/1ps
module tb_pmm_switchback_ctrl;
    localparam int N_IRQ  = 6;
    localparam int N_SER  = 2;
    localparam int STAT_W = 2 + 2 * N_SER;

    logic clk = 0;
    logic rst_n = 0;
    logic cyc_tick = 0, mode_wr = 0, osc_wr = 0, osc_wdata = 0;
    logic [1:0] mode_wdata = 0;
    logic [N_IRQ-1:0] irq_req = 0, irq_hi = 0;
    logic svc_hi = 0, svc_lo = 0;
    logic [N_SER-1:0] ser_start = 0, ser_rx_act = 0, ser_tx_act = 0;
    logic [1:0] div_sel, mode_q;
    logic osc_sel;
    logic [STAT_W-1:0] status;

    // staged stimulus
    logic s_tick, s_mwr, s_owr, s_owd, s_shi, s_slo;
    logic [1:0] s_mwd;
    logic [N_IRQ-1:0] s_irq, s_ihi;
    logic [N_SER-1:0] s_start, s_rx, s_tx;

    // model state
    logic [1:0] m_div, m_mode;
    logic m_osc;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pmm_switchback_ctrl #(.N_IRQ(N_IRQ), .N_SER(N_SER)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .osc_wr(osc_wr), .osc_wdata(osc_wdata),
        .irq_req(irq_req), .irq_hi(irq_hi), .svc_hi(svc_hi), .svc_lo(svc_lo),
        .ser_start(ser_start), .ser_rx_act(ser_rx_act), .ser_tx_act(ser_tx_act),
        .div_sel(div_sel), .mode_q(mode_q), .osc_sel(osc_sel), .status(status)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R6 R7: wake qualification from the requirements
    function automatic logic f_wake(logic [N_IRQ-1:0] irq, logic [N_IRQ-1:0] hi,
                                    logic shi, logic slo, logic [N_SER-1:0] st);
        logic [N_IRQ-1:0] ok;
        if (shi)      ok = '0;
        else if (slo) ok = irq & hi;
        else          ok = irq;
        return (ok != '0) || (st != '0);
    endfunction

    // R10
    function automatic logic [STAT_W-1:0] f_status(logic shi, logic slo,
                                    logic [N_SER-1:0] rx, logic [N_SER-1:0] tx);
        logic [STAT_W-1:0] s;
        s[0] = shi;
        s[1] = slo;
        for (int p = 0; p < N_SER; p++) begin
            s[2 + 2*p] = rx[p];
            s[3 + 2*p] = tx[p];
        end
        return s;
    endfunction

    task automatic stage_idle();
        s_tick = 0; s_mwr = 0; s_mwd = 0; s_owr = 0; s_owd = 0;
        s_irq = 0; s_ihi = 0; s_shi = 0; s_slo = 0;
        s_start = 0; s_rx = 0; s_tx = 0;
    endtask

    task automatic step(string tag);
        logic w;
        @(negedge clk);
        cyc_tick = s_tick; mode_wr = s_mwr; mode_wdata = s_mwd;
        osc_wr = s_owr; osc_wdata = s_owd; irq_req = s_irq; irq_hi = s_ihi;
        svc_hi = s_shi; svc_lo = s_slo; ser_start = s_start;
        ser_rx_act = s_rx; ser_tx_act = s_tx;
        #1;
        check("R10 status", int'(status), int'(f_status(s_shi, s_slo, s_rx, s_tx)));
        w = f_wake(s_irq, s_ihi, s_shi, s_slo, s_start);
        if (m_div != 2'b00) begin
            if (w || (s_mwr && s_mwd == 2'b00)) begin m_div = 0; m_mode = 0; end
        end else if (m_mode != 2'b00) begin
            if (w || (s_mwr && s_mwd == 2'b00)) m_mode = 0;
            else if (s_tick) m_div = m_mode;
        end else if (s_mwr && (s_mwd == 2'b01 || s_mwd == 2'b10)) begin
            m_mode = s_mwd;
        end
        if (s_owr) m_osc = s_owd;
        @(posedge clk);
        #1;
        check({tag, " div_sel"}, int'(div_sel), int'(m_div));
        check({tag, " mode_q"}, int'(mode_q), int'(m_mode));
        check("R9 osc_sel", int'(osc_sel), int'(m_osc));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        stage_idle();
        m_div = 0; m_mode = 0; m_osc = 1;
        repeat (4) @(posedge clk);
        #1;
        // R1
        check("R1 div_sel", int'(div_sel), 0);
        check("R1 mode_q", int'(mode_q), 0);
        check("R1 osc_sel", int'(osc_sel), 1);
        @(negedge clk); rst_n = 1;

        // R2: arm, no boundary yet
        stage_idle(); s_mwr = 1; s_mwd = 2'b01; step("R2");
        stage_idle(); step("R2");
        stage_idle(); s_tick = 1; step("R2");
        check("R3 div64 code", int'(div_sel), 1);
        // R4: direct jump and 11 refused
        stage_idle(); s_mwr = 1; s_mwd = 2'b10; s_tick = 1; step("R4");
        stage_idle(); s_mwr = 1; s_mwd = 2'b11; step("R4");
        // R6: high level masks everything
        stage_idle(); s_shi = 1; s_irq = 6'b000011; s_ihi = 6'b000001; step("R6");
        check("R6 masked hi", int'(div_sel), 1);
        // R6: low level masks low-priority
        stage_idle(); s_slo = 1; s_irq = 6'b000100; s_ihi = 6'b000011; step("R6");
        check("R6 masked lo", int'(div_sel), 1);
        // R5: high-priority request while low level in service wakes
        stage_idle(); s_slo = 1; s_irq = 6'b000100; s_ihi = 6'b000100; step("R5");
        check("R5 wake div", int'(div_sel), 0);
        check("R9 untouched by wake", int'(osc_sel), 1);
        // R3 div1024, R7 serial wake under high level
        stage_idle(); s_mwr = 1; s_mwd = 2'b10; step("R3");
        stage_idle(); s_tick = 1; step("R3");
        check("R3 div1024 code", int'(div_sel), 2);
        stage_idle(); s_owr = 1; s_owd = 0; step("R9");
        stage_idle(); s_shi = 1; s_start = 2'b10; step("R7");
        check("R7 serial wake", int'(div_sel), 0);
        check("R9 untouched by wake", int'(osc_sel), 0);
        // R8: wake cancels arm
        stage_idle(); s_mwr = 1; s_mwd = 2'b01; step("R8");
        stage_idle(); s_irq = 6'b100000; step("R8");
        stage_idle(); s_tick = 1; step("R8");
        check("R8 cancelled", int'(div_sel), 0);
        // R3: 11 from full ignored
        stage_idle(); s_mwr = 1; s_mwd = 2'b11; s_tick = 1; step("R3");
        // R4: software exit
        stage_idle(); s_mwr = 1; s_mwd = 2'b10; s_tick = 1; step("R4");
        stage_idle(); s_tick = 1; step("R4");
        stage_idle(); s_mwr = 1; s_mwd = 2'b00; step("R4");
        check("R4 sw exit", int'(div_sel), 0);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            stage_idle();
            s_mwr  = ($urandom % 4) == 0;
            s_mwd  = 2'($urandom % 4);
            s_tick = ($urandom % 4) == 0;
            s_ihi  = N_IRQ'($urandom);
            if (($urandom % 12) == 0) s_irq = N_IRQ'(1) << ($urandom % N_IRQ);
            s_shi  = ($urandom % 4) == 0;
            s_slo  = ($urandom % 3) == 0;
            if (($urandom % 40) == 0) s_start = N_SER'(1) << ($urandom % N_SER);
            s_rx   = N_SER'($urandom);
            s_tx   = N_SER'($urandom);
            s_owr  = ($urandom % 16) == 0;
            s_owd  = 1'($urandom);
            step("R5 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule